// File: doc/BRIEF.md
# Two-Way Modal Token Router

This block is a self-timed dataflow actor that steers each incoming data token to one of two output streams. The route for every data token comes from a Boolean selector token that arrives on its own input stream. The actor alternates between a selector-reading step and a data-moving step, and it never combines the two in one cycle.

Internally the actor keeps a small mode register with three states: a selector-wait state, a route-to-true state and a route-to-false state. Each state has fixed token rates.

- In the selector-wait state a firing takes one selector token and moves no data.
- In either route state a firing takes one data token and emits it on the one output that belongs to that state.

A firing happens only when the tokens it consumes are present and the output it writes can accept a token. Every port uses a valid/ready handshake, so it can face a FIFO directly. The actor fires by itself whenever these conditions hold, with at most one firing per clock cycle.

Top module: `route_actor`

## Requirements
- R1: After reset the actor is in selector-wait state: `sel_ready`=1, `din_ready`=0, `tru_valid`=0, `fal_valid`=0.
- R2: In selector-wait state no data token is accepted and no output is valid, even while `din_valid`=1. Without `sel_valid`, the actor stays in that state.
- R3: A selector firing (`sel_valid`&`sel_ready` at a clock edge) whose bit 0 is 1 moves the actor to the route-to-true state from the next cycle. In that state `sel_ready`=0 and `fal_valid`=0.
- R4: A selector firing whose bit 0 is 0 moves the actor to the route-to-false state from the next cycle. In that state `sel_ready`=0 and `tru_valid`=0.
- R5: In route-to-true state, `tru_valid` equals `din_valid`, `tru_data` equals `din_data`, and `din_ready` equals `tru_ready`. The data token moves in the cycle both handshakes complete.
- R6: In route-to-false state, `fal_valid` equals `din_valid`, `fal_data` equals `din_data`, and `din_ready` equals `fal_ready`.
- R7: After a data firing, the actor is back in selector-wait state in the next cycle (`sel_ready`=1).
- R8: While the selected output is not ready, `din_ready`=0 and the route state holds, so no token is lost or duplicated. The ready of the unselected output has no effect.
- R9: Only bit 0 of the selector token chooses the route. The upper bits have no effect.
- R10: At most one firing per cycle: `sel_ready` and `din_ready` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Selector token present |
| sel_ready | output | 1 | Selector token taken this cycle if valid |
| sel_data | input | SEL_W | Selector token; bit 0 is the route |
| din_valid | input | 1 | Data token present |
| din_ready | output | 1 | Data token taken this cycle if valid |
| din_data | input | DATA_W | Data token |
| tru_valid | output | 1 | Token offered on the true stream |
| tru_ready | input | 1 | True stream can take a token |
| tru_data | output | DATA_W | True stream token |
| fal_valid | output | 1 | Token offered on the false stream |
| fal_ready | input | 1 | False stream can take a token |
| fal_data | output | DATA_W | False stream token |

## Verification
The hardest case to reach is a route state held under backpressure while the other output is ready and a data token is waiting. The bench builds this case on purpose. It holds the selected ready low for several cycles after a selector firing, raises the opposite ready, and checks that the token is neither dropped nor sent out twice. A second phase toggles both output readies each cycle under a changing selector pattern, with upper selector bits set against bit 0. In that phase a scoreboard checks the order and the routing of every token.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        MODE_SEL = 2'b00,
        MODE_TRU = 2'b01,
        MODE_FAL = 2'b10
    } mode_e;

    localparam int NUM_LANES = 2;

    typedef struct packed {
        mode_e mode;
    } rt_state_t;
endpackage

// File: rtl/rt_guard.sv
module rt_guard
    import rt_pkg::*;
#(
    parameter int LANES = NUM_LANES
) (
    input  mode_e              mode_q,
    input  logic               sel_valid,
    output logic               sel_ready,
    input  logic               din_valid,
    output logic               din_ready,
    input  logic [LANES-1:0]   out_ready,
    output logic [LANES-1:0]   out_valid,
    output logic               fire_sel,
    output logic               fire_dat
);
    logic [LANES-1:0] lane_sel;

    // lane k is owned by route mode k+1 (lane 0 true, lane 1 false)
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_sel[k]  = (mode_q == mode_e'(k + 1));
            assign out_valid[k] = lane_sel[k] & din_valid;
        end
    endgenerate

    assign sel_ready = (mode_q == MODE_SEL);
    assign din_ready = |(lane_sel & out_ready);
    assign fire_sel  = sel_valid & sel_ready;
    assign fire_dat  = din_valid & din_ready;
endmodule

// File: rtl/rt_mode_reg.sv
module rt_mode_reg
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fire_sel,
    input  logic  fire_dat,
    input  logic  sel_bit,
    output mode_e mode_q
);
    rt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_sel) begin
            st_d.mode = sel_bit ? MODE_TRU : MODE_FAL;
        end else if (fire_dat) begin
            st_d.mode = MODE_SEL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SEL};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
endmodule

// File: rtl/route_actor.sv
module route_actor
    import rt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid,
    output logic              sel_ready,
    input  logic [SEL_W-1:0]  sel_data,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [DATA_W-1:0] din_data,
    output logic              tru_valid,
    input  logic              tru_ready,
    output logic [DATA_W-1:0] tru_data,
    output logic              fal_valid,
    input  logic              fal_ready,
    output logic [DATA_W-1:0] fal_data
);
    mode_e                mode_q;
    logic                 fire_sel, fire_dat;
    logic [NUM_LANES-1:0] lane_valid;
    logic                 unused_sel_hi;

    // only bit 0 of the selector token carries the route
    assign unused_sel_hi = ^sel_data[SEL_W-1:1];

    rt_guard #(.LANES(NUM_LANES)) u_guard (
        .mode_q    (mode_q),
        .sel_valid (sel_valid),
        .sel_ready (sel_ready),
        .din_valid (din_valid),
        .din_ready (din_ready),
        .out_ready ({fal_ready, tru_ready}),
        .out_valid (lane_valid),
        .fire_sel  (fire_sel),
        .fire_dat  (fire_dat)
    );

    rt_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_sel (fire_sel),
        .fire_dat (fire_dat),
        .sel_bit  (sel_data[0]),
        .mode_q   (mode_q)
    );

    assign tru_valid = lane_valid[0];
    assign fal_valid = lane_valid[1];
    assign tru_data  = din_data;
    assign fal_data  = din_data;
endmodule

// File: rtl/rt_chk.sv
module rt_chk #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_valid,
    input logic              sel_ready,
    input logic [SEL_W-1:0]  sel_data,
    input logic              din_valid,
    input logic              din_ready,
    input logic [DATA_W-1:0] din_data,
    input logic              tru_valid,
    input logic              tru_ready,
    input logic [DATA_W-1:0] tru_data,
    input logic              fal_valid,
    input logic              fal_ready,
    input logic [DATA_W-1:0] fal_data
);
    // R10
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ready && din_ready));

    // R3
    go_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_ready && sel_data[0]) |=> (!sel_ready && !fal_valid));

    // R4
    go_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_ready && !sel_data[0]) |=> (!sel_ready && !tru_valid));

    // R7
    back_to_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din_ready) |=> sel_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tru_valid && !tru_ready) |=> (!sel_ready && !fal_valid));

    // R5
    true_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tru_valid |-> (tru_data == din_data && !fal_valid));

    // R6
    false_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fal_valid |-> (fal_data == din_data && !tru_valid));

    // R2
    no_data_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ready |-> (!din_ready && !tru_valid && !fal_valid));
endmodule

bind route_actor rt_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_data(sel_data),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .tru_valid(tru_valid), .tru_ready(tru_ready), .tru_data(tru_data),
    .fal_valid(fal_valid), .fal_ready(fal_ready), .fal_data(fal_data)
);

// File: tb/sim_route_actor.sv
`timescale 1ns/1ps
module sim_route_actor;
    localparam int DW = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_valid = 1'b0;
    logic          sel_ready;
    logic [SW-1:0] sel_data = '0;
    logic          din_valid = 1'b0;
    logic          din_ready;
    logic [DW-1:0] din_data = '0;
    logic          tru_valid, fal_valid;
    logic          tru_ready = 1'b1, fal_ready = 1'b1;
    logic [DW-1:0] tru_data, fal_data;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    bit  bp_en = 0;
    bit  prev_fire = 0;
    logic [DW-1:0] q_t[$];
    logic [DW-1:0] q_f[$];

    always #2 clk = ~clk;

    route_actor #(.DATA_W(DW), .SEL_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_data(sel_data),
        .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
        .tru_valid(tru_valid), .tru_ready(tru_ready), .tru_data(tru_data),
        .fal_valid(fal_valid), .fal_ready(fal_ready), .fal_data(fal_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic put_sel(input logic [SW-1:0] s);
        @(posedge clk) #1;
        sel_valid = 1'b1;
        sel_data  = s;
        forever begin
            @(negedge clk);
            if (sel_ready) break;
        end
        @(posedge clk) #1;
        sel_valid = 1'b0;
    endtask

    task automatic put_dat(input logic [DW-1:0] d);
        din_valid = 1'b1;
        din_data  = d;
        forever begin
            @(negedge clk);
            if (din_ready) break;
        end
        @(posedge clk) #1;
        din_valid = 1'b0;
    endtask

    // driver: expected item goes into the queue of the route bit 0 picks (R9)
    task automatic send(input logic [SW-1:0] s, input logic [DW-1:0] d);
        if (s[0]) q_t.push_back(d);
        else      q_f.push_back(d);
        put_sel(s);
        put_dat(d);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_fire) chk(sel_ready == 1'b1, "R7 back to selector wait", sel_ready, 1);
            prev_fire = din_valid && din_ready;
            if (tru_valid && tru_ready) begin
                if (q_t.size() == 0) chk(0, "R5 unexpected true token", tru_data, 0);
                else chk(tru_data == q_t.pop_front(), "R5 true data", tru_data, din_data);
                chk(!fal_valid, "R5 false stream quiet", fal_valid, 0);
            end
            if (fal_valid && fal_ready) begin
                if (q_f.size() == 0) chk(0, "R6 unexpected false token", fal_data, 0);
                else chk(fal_data == q_f.pop_front(), "R6 false data", fal_data, din_data);
                chk(!tru_valid, "R6 true stream quiet", tru_valid, 0);
            end
            chk(!(sel_ready && din_ready), "R10 one firing", {sel_ready, din_ready}, 0);
        end
    end

    // backpressure pattern
    int bp_cnt = 0;
    always @(posedge clk) begin
        if (bp_en) begin
            #1;
            bp_cnt++;
            tru_ready = (bp_cnt % 3) != 0;
            fal_ready = (bp_cnt % 4) != 1;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel_ready == 1, "R1 sel_ready", sel_ready, 1);
        chk(din_ready == 0, "R1 din_ready", din_ready, 0);
        chk(!tru_valid && !fal_valid, "R1 outputs idle", {tru_valid, fal_valid}, 0);
        @(posedge clk) #1 rst_n = 1'b1;

        // R2: data waiting, no selector
        din_valid = 1'b1;
        din_data  = 8'h33;
        repeat (3) begin
            @(negedge clk);
            chk(din_ready == 0, "R2 no data in selector wait", din_ready, 0);
            chk(!tru_valid && !fal_valid, "R2 outputs idle", {tru_valid, fal_valid}, 0);
            chk(sel_ready == 1, "R2 stays in selector wait", sel_ready, 1);
        end
        @(posedge clk) #1 din_valid = 1'b0;

        // R3 / R4 / R5 / R6 basic routing
        send(4'h1, 8'hA1);
        send(4'h0, 8'hB2);
        // R9: upper bits set, bit 0 clear -> false route; and reverse
        send(4'hE, 8'hC3);
        send(4'h9, 8'hD4);

        // R8: stall on true output, false output ready
        tru_ready = 1'b0;
        fal_ready = 1'b1;
        put_sel(4'h1);
        q_t.push_back(8'h5A);
        din_valid = 1'b1;
        din_data  = 8'h5A;
        repeat (3) begin
            @(negedge clk);
            chk(din_ready == 0, "R8 stalled din_ready", din_ready, 0);
            chk(tru_valid == 1, "R8 token held on true", tru_valid, 1);
            chk(fal_valid == 0 && sel_ready == 0, "R8 route state held",
                {fal_valid, sel_ready}, 0);
        end
        @(posedge clk) #1 tru_ready = 1'b1;
        @(posedge clk) #1 din_valid = 1'b0;
        @(negedge clk);
        chk(q_t.size() == 0, "R8 held token delivered once", q_t.size(), 0);

        // mixed pattern with backpressure on both outputs
        bp_en = 1;
        for (int i = 0; i < 24; i++) begin
            send(SW'((i * 7) ^ (i >> 1)), DW'((i * 37) ^ 8'hA5));
        end
        bp_en = 0;
        @(posedge clk) #1;
        tru_ready = 1'b1;
        fal_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(q_t.size() == 0, "R5 all true tokens seen", q_t.size(), 0);
        chk(q_f.size() == 0, "R6 all false tokens seen", q_f.size(), 0);
        chk(sel_ready == 1, "R7 idle in selector wait", sel_ready, 1);
        finish_run();
    end
endmodule